// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block sits between a synchronous host and an asynchronous extended-data-out DRAM organised as 1M words of 4 bits. It takes one word per request through a valid/ready handshake. For each request it produces the strobe sequence the memory needs: row strobe, column strobe, write enable and output enable. It splits the 20-bit word address into row and column halves that share one 10-bit address bus.

Every analog limit is given as a nanosecond parameter. Each one is turned into a whole number of clocks by rounding up against the clock-period parameter. The results are checked against the maximum limits when the design is elaborated.

A separate refresh scheduler raises a level request. The sequencer serves it with a column-before-row refresh slot, and that slot takes precedence over host traffic waiting at the same time. Writes use early-write timing. Reads sample the data bus on the last clock of the column strobe and return it with a single-cycle valid pulse.

Top module: `edo_seq_ctrl`

## Requirements
- R1: While reset is held and just after it is released, all four strobe outputs (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_oe_n`) are high, `dram_dq_oe` is low, `rsp_valid` is low and `req_ready` is high.
- R2: An access drives `req_addr[19:10]` on `dram_addr` when the row strobe falls, and keeps it there for ceil(10 ns / period) clocks. It then drives `req_addr[9:0]`, which is present when the column strobe falls.
- R3: In an access, the column strobe falls exactly ceil(20 ns / period) clocks after the row strobe, and stays low for max(ceil(15/P), ceil(10/P), ceil(60/P) − RCD) clocks. The row strobe is released together with the column strobe and is never low longer than 10 µs.
- R4: The row strobe stays high for at least ceil(40 ns / period) clocks between two low pulses. Successive row-strobe falls are at least ceil(110 ns / period) clocks apart.
- R5: A write drives `dram_we_n` low in the clock before the column strobe falls and keeps it low while the column strobe is low. It keeps `dram_oe_n` high throughout, and drives `req_wdata` with `dram_dq_oe` high when the column strobe falls.
- R6: A read keeps `dram_we_n` high and drives `dram_oe_n` low while the column strobe is low. It samples `dram_dq_in` at the final column-low clock and returns that value on `rsp_rdata`.
- R7: A refresh slot lowers the column strobe ceil(10 ns / period) clocks before the row strobe. It then holds both strobes low for ceil(60 ns / period) clocks, keeps `dram_we_n` high and does not drive the data bus. `ref_ack` is high in the single clock in which the slot is taken.
- R8: A pending `ref_req` is served before a host request that is waiting at the same time. `req_ready` is low whenever the sequencer is not idle or `ref_req` is high.
- R9: `rsp_valid` is a one-clock pulse raised exactly once per read and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in upper half |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 4 | Read data |
| ref_req | input | 1 | Refresh request level from scheduler |
| ref_ack | output | 1 | Refresh slot taken this clock |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data toward memory |
| dram_dq_oe | output | 1 | Drive enable for data pads |
| dram_dq_in | input | 4 | Data from memory |

## Verification
A vector table runs writes and reads back to back. It uses addresses that share a column but differ in row, addresses that share a row but differ in column, the all-zero and all-one corners, and one location that was never written. A swapped or truncated address half therefore returns the wrong nibble. The memory model in the bench returns inverted data whenever it is sampled before both access times have elapsed, so a short column phase is exposed by the data itself. A directed case raises a refresh request and a host read in the same clock, which separates correct priority and correct refresh strobe order from a sequencer that serves the host first.

// File: rtl/edo_seq_pkg.sv
`timescale 1ns/1ps
package edo_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_RAS,
      ST_CAS,
      ST_PRE,
      ST_RCAS,
      ST_RRAS
   } seq_state_e;

   // whole clocks covering a nanosecond limit
   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
      return (ns + per - 1) / per;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/edo_phase_timer.sv
`timescale 1ns/1ps
module edo_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/edo_addr_mux.sv
`timescale 1ns/1ps
module edo_addr_mux #(
   parameter int ROW_W = 10
) (
   input  logic [ROW_W-1:0] row,
   input  logic [ROW_W-1:0] col,
   input  logic             use_row,
   output logic [ROW_W-1:0] addr
);

   generate
      for (genvar b = 0; b < ROW_W; b++) begin : g_bit
         assign addr[b] = use_row ? row[b] : col[b];
      end
   endgenerate

endmodule

// File: rtl/edo_rd_capture.sv
`timescale 1ns/1ps
module edo_rd_capture #(
   parameter int DQ_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            capture,
   input  logic [DQ_W-1:0] dq_in,
   output logic            rsp_valid,
   output logic [DQ_W-1:0] rsp_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= capture;
         if (capture) rsp_rdata <= dq_in;
      end
   end

   // R9
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/edo_seq_ctrl.sv
`timescale 1ns/1ps
module edo_seq_ctrl
   import edo_seq_pkg::*;
#(
   parameter int unsigned CLK_NS       = 10,
   parameter int unsigned ROW_W        = 10,
   parameter int unsigned DQ_W         = 4,
   parameter int unsigned T_RP_NS      = 40,
   parameter int unsigned T_RC_NS      = 110,
   parameter int unsigned T_RAS_NS     = 60,
   parameter int unsigned T_RAS_MAX_NS = 10000,
   parameter int unsigned T_CAS_NS     = 10,
   parameter int unsigned T_RCD_NS     = 20,
   parameter int unsigned T_RCD_MAX_NS = 45,
   parameter int unsigned T_RAH_NS     = 10,
   parameter int unsigned T_CAC_NS     = 15,
   parameter int unsigned T_RAC_NS     = 60,
   parameter int unsigned T_CSR_NS     = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [2*ROW_W-1:0]   req_addr,
   input  logic [DQ_W-1:0]      req_wdata,
   output logic                 rsp_valid,
   output logic [DQ_W-1:0]      rsp_rdata,
   input  logic                 ref_req,
   output logic                 ref_ack,
   output logic                 dram_ras_n,
   output logic                 dram_cas_n,
   output logic                 dram_we_n,
   output logic                 dram_oe_n,
   output logic [ROW_W-1:0]     dram_addr,
   output logic [DQ_W-1:0]      dram_dq_out,
   output logic                 dram_dq_oe,
   input  logic [DQ_W-1:0]      dram_dq_in
);

   localparam int unsigned AW       = 2 * ROW_W;
   localparam int unsigned RCD_CYC  = umax(ns2cyc(T_RCD_NS, CLK_NS), 1);
   localparam int unsigned RAH_CYC  = umax(ns2cyc(T_RAH_NS, CLK_NS), 1);
   localparam int unsigned RAS_NEED = umax(ns2cyc(T_RAS_NS, CLK_NS), ns2cyc(T_RAC_NS, CLK_NS));
   localparam int unsigned CAS_CYC  = umax(umax(ns2cyc(T_CAC_NS, CLK_NS), ns2cyc(T_CAS_NS, CLK_NS)),
                                           (RAS_NEED > RCD_CYC) ? RAS_NEED - RCD_CYC : 1);
   localparam int unsigned RC_CYC   = ns2cyc(T_RC_NS, CLK_NS);
   localparam int unsigned RP_CYC   = umax(umax(ns2cyc(T_RP_NS, CLK_NS), 1),
                                           (RC_CYC > RCD_CYC + CAS_CYC) ? RC_CYC - RCD_CYC - CAS_CYC : 1);
   localparam int unsigned CSR_CYC  = umax(ns2cyc(T_CSR_NS, CLK_NS), 1);
   localparam int unsigned RREF_CYC = umax(ns2cyc(T_RAS_NS, CLK_NS), 1);
   localparam int unsigned MAX_PH   = umax(umax(umax(RCD_CYC, CAS_CYC), umax(RP_CYC, CSR_CYC)), RREF_CYC);
   localparam int          CNT_W    = $clog2(MAX_PH + 1);
   localparam int unsigned ROW_LAST = RCD_CYC - RAH_CYC;
   localparam int unsigned RAS_MAX_CYC = T_RAS_MAX_NS / CLK_NS;
   localparam int          LO_W     = $clog2(RAS_MAX_CYC + 1) + 1;
   localparam int          HI_W     = $clog2(RP_CYC + 2) + 1;

   // elaboration-time limit checks
   generate
      if (ROW_W < 1 || DQ_W < 1) begin : g_bad_width
         $error("edo_seq_ctrl: widths must be positive");
      end
      if (RCD_CYC * CLK_NS > T_RCD_MAX_NS) begin : g_bad_rcd
         $error("edo_seq_ctrl: row-to-column delay exceeds its maximum");
      end
      if (RAH_CYC > RCD_CYC) begin : g_bad_rah
         $error("edo_seq_ctrl: row hold longer than row-to-column delay");
      end
      if ((RCD_CYC + CAS_CYC) * CLK_NS > T_RAS_MAX_NS || RREF_CYC * CLK_NS > T_RAS_MAX_NS) begin : g_bad_ras
         $error("edo_seq_ctrl: row strobe low time exceeds its maximum");
      end
   endgenerate

   seq_state_e       state_q, state_d;
   logic [CNT_W-1:0] t_cnt, t_val;
   logic             t_done, t_load;
   logic             wr_q;
   logic [AW-1:0]    addr_q;
   logic [DQ_W-1:0]  wdata_q;
   logic             take_ref, take_host;
   logic             row_sel, access_lo, capture;

   assign take_ref  = (state_q == ST_IDLE) && ref_req;
   assign take_host = (state_q == ST_IDLE) && !ref_req && req_valid;
   assign req_ready = (state_q == ST_IDLE) && !ref_req;
   assign ref_ack   = take_ref;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (take_ref)       state_d = ST_RCAS;
            else if (take_host) state_d = ST_ROW;
         end
         ST_ROW:  if (t_done) state_d = ST_RAS;
         ST_RAS:  if (t_done) state_d = ST_CAS;
         ST_CAS:  if (t_done) state_d = ST_PRE;
         ST_PRE:  if (t_done) state_d = ST_IDLE;
         ST_RCAS: if (t_done) state_d = ST_RRAS;
         ST_RRAS: if (t_done) state_d = ST_PRE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (state_d)
         ST_RAS:  t_val = CNT_W'(RCD_CYC - 1);
         ST_CAS:  t_val = CNT_W'(CAS_CYC - 1);
         ST_PRE:  t_val = CNT_W'(RP_CYC - 1);
         ST_RCAS: t_val = CNT_W'(CSR_CYC - 1);
         ST_RRAS: t_val = CNT_W'(RREF_CYC - 1);
         default: t_val = '0;
      endcase
   end

   assign t_load = (state_d != state_q);

   edo_phase_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .cnt      (t_cnt),
      .done     (t_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         state_q <= state_d;
         if (take_host) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
      end
   end

   // strobe decode
   assign access_lo   = (state_q == ST_RAS) || (state_q == ST_CAS);
   assign dram_ras_n  = !(access_lo || (state_q == ST_RRAS));
   assign dram_cas_n  = !((state_q == ST_CAS) || (state_q == ST_RCAS) || (state_q == ST_RRAS));
   assign dram_we_n   = !(wr_q && access_lo);
   assign dram_oe_n   = !(!wr_q && (state_q == ST_CAS));
   assign dram_dq_oe  = wr_q && access_lo;
   assign dram_dq_out = wdata_q;

   assign row_sel = (state_q == ST_ROW) ||
                    ((state_q == ST_RAS) && ({1'b0, t_cnt} >= (CNT_W+1)'(ROW_LAST)));

   edo_addr_mux #(.ROW_W(ROW_W)) i_amux (
      .row     (addr_q[AW-1:ROW_W]),
      .col     (addr_q[ROW_W-1:0]),
      .use_row (row_sel),
      .addr    (dram_addr)
   );

   assign capture = (state_q == ST_CAS) && t_done && !wr_q;

   edo_rd_capture #(.DQ_W(DQ_W)) i_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (capture),
      .dq_in     (dram_dq_in),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   // strobe-age counters for the timing checks below
   logic [LO_W-1:0] ras_lo_cnt;
   logic [HI_W-1:0] ras_hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_lo_cnt <= '0;
         ras_hi_cnt <= HI_W'(RP_CYC);
      end else if (dram_ras_n) begin
         ras_lo_cnt <= '0;
         if (ras_hi_cnt != '1) ras_hi_cnt <= ras_hi_cnt + 1'b1;
      end else begin
         ras_hi_cnt <= '0;
         if (ras_lo_cnt != '1) ras_lo_cnt <= ras_lo_cnt + 1'b1;
      end
   end

   // R3
   ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_ras_n |-> (ras_lo_cnt < LO_W'(RAS_MAX_CYC)));

   // R3
   rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_cas_n) && !dram_ras_n) |-> (ras_lo_cnt == LO_W'(RCD_CYC)));

   // R4
   precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> (ras_hi_cnt >= HI_W'(RP_CYC)));

   // R5
   early_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));

   // R5
   we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_we_n |-> dram_oe_n);

   // R6
   bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dram_dq_oe |-> dram_oe_n);

   // R7
   cbr_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && dram_ras_n) |-> (dram_we_n && !dram_dq_oe));

   // R8
   ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |-> !req_ready);

endmodule

// File: tb/test_edo_seq_ctrl.sv
`timescale 1ns/1ps
module test_edo_seq_ctrl;

   localparam int P       = 5;
   localparam int E_RCD   = (20 + P - 1) / P;
   localparam int E_RAH   = (10 + P - 1) / P;
   localparam int E_CAC   = (15 + P - 1) / P;
   localparam int E_CMIN  = (10 + P - 1) / P;
   localparam int E_RAC   = (60 + P - 1) / P;
   localparam int E_CAS0  = (E_CAC > E_CMIN) ? E_CAC : E_CMIN;
   localparam int E_CAS   = (E_CAS0 > E_RAC - E_RCD) ? E_CAS0 : E_RAC - E_RCD;
   localparam int E_RP    = (40 + P - 1) / P;
   localparam int E_RC    = (110 + P - 1) / P;
   localparam int E_CSR   = (10 + P - 1) / P;
   localparam int E_RREF  = (60 + P - 1) / P;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
   logic [19:0] req_addr = '0;
   logic [3:0]  req_wdata = '0;
   logic        req_ready, rsp_valid, ref_ack;
   logic [3:0]  rsp_rdata;
   logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
   logic [9:0]  dram_addr;
   logic [3:0]  dram_dq_out, dram_dq_in;

   always #2.5 clk = ~clk;

   edo_seq_ctrl #(.CLK_NS(P)) i_edo_seq_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .ref_req(ref_req), .ref_ack(ref_ack),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
      .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
      .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
      .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- memory model and strobe monitor ----------------
   logic [3:0] mem [logic [19:0]];
   logic [3:0] m_rdval = 4'h0;
   int ras_age = 0, cas_age = 0;

   always @(posedge clk) begin
      ras_age <= dram_ras_n ? 0 : ras_age + 1;
      cas_age <= dram_cas_n ? 0 : cas_age + 1;
   end

   assign dram_dq_in = (!dram_oe_n && !dram_cas_n &&
                        ((cas_age + 1) * P >= 15) && ((ras_age + 1) * P >= 60)) ? m_rdval : ~m_rdval;

   bit p_ras = 1, p_cas = 1, p_we = 1, p_rsp = 0;
   int ras_lo = 0, ras_hi = 0, since_fall = 0, cas_lo = 0;
   int m_rcd = 0, m_cas_len = 0, m_ras_len = 0, m_cas_lead = 0;
   int m_min_hi = 9999, m_min_per = 9999, rah_bad = 0, cbr_we_bad = 0;
   int n_ras_falls = 0, n_cbr = 0, rsp_cnt = 0, rsp_long = 0;
   logic [9:0] m_row = '0, m_col = '0;
   logic [3:0] m_dq = '0;
   bit m_cbr = 0, m_we_at_cas = 1, m_oe_at_cas = 1, m_we_pre = 1, m_dqoe = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         since_fall++;
         if (p_ras && !dram_ras_n) begin
            if (n_ras_falls > 0) begin
               if (ras_hi < m_min_hi) m_min_hi = ras_hi;
               if (since_fall < m_min_per) m_min_per = since_fall;
            end
            since_fall = 0;
            m_row = dram_addr;
            m_cbr = !dram_cas_n;
            if (m_cbr) begin
               m_cas_lead = cas_lo;
               n_cbr++;
            end
            n_ras_falls++;
            ras_lo = 0;
         end
         if (!dram_ras_n && p_cas && !dram_cas_n) begin
            m_rcd       = ras_lo;
            m_col       = dram_addr;
            m_we_at_cas = dram_we_n;
            m_oe_at_cas = dram_oe_n;
            m_we_pre    = p_we;
            m_dq        = dram_dq_out;
            m_dqoe      = dram_dq_oe;
            if (!dram_we_n) mem[{m_row, dram_addr}] = dram_dq_out;
            m_rdval = mem.exists({m_row, dram_addr}) ? mem[{m_row, dram_addr}]
                                                     : (dram_addr[3:0] ^ 4'h5);
         end
         if (!dram_ras_n && !m_cbr && ras_lo < E_RAH && dram_addr != m_row) rah_bad++;
         if (!dram_cas_n && !dram_we_n && (dram_ras_n || m_cbr)) cbr_we_bad++;
         if (!p_ras && dram_ras_n) begin
            m_ras_len = ras_lo;
            ras_hi = 0;
         end
         if (p_cas && !dram_cas_n) cas_lo = 0;
         if (!p_cas && dram_cas_n) m_cas_len = cas_lo;
         if (!dram_ras_n) ras_lo++;
         else ras_hi++;
         if (!dram_cas_n) cas_lo++;
         if (rsp_valid) begin
            rsp_cnt++;
            if (p_rsp) rsp_long++;
         end
         p_ras = dram_ras_n;
         p_cas = dram_cas_n;
         p_we  = dram_we_n;
         p_rsp = rsp_valid;
      end
   end

   // ---------------- host access task ----------------
   task automatic access(input bit wr, input logic [19:0] a, input logic [3:0] d,
                         output logic [3:0] got, output int nrsp);
      int base;
      got = 4'hx;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      base = rsp_cnt;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 100 && !req_ready; i++) begin
         if (rsp_valid) got = rsp_rdata;
         @(negedge clk);
      end
      @(negedge clk);
      nrsp = rsp_cnt - base;
   endtask

   // {write, addr[19:0], data or expected read value}
   localparam logic [24:0] VEC [0:10] = '{
      {1'b1, 20'h00000, 4'h3},
      {1'b1, 20'hFFFFF, 4'hC},
      {1'b1, 20'h00401, 4'h9},
      {1'b1, 20'h00801, 4'h6},
      {1'b1, 20'h00402, 4'hA},
      {1'b0, 20'h00401, 4'h9},
      {1'b0, 20'h00801, 4'h6},
      {1'b0, 20'h00402, 4'hA},
      {1'b0, 20'hFFFFF, 4'hC},
      {1'b0, 20'h00000, 4'h3},
      {1'b0, 20'h12345, 4'h0}
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [3:0] got;
      int nrsp, falls0, cbr0;
      repeat (4) @(negedge clk);
      // R1 during reset
      check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !rsp_valid,
            "R1 strobes in reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !rsp_valid && dram_ras_n && dram_cas_n, "R1 after reset",
            {req_ready, rsp_valid}, 2);

      for (int v = 0; v < 11; v++) begin
         logic        wr;
         logic [19:0] a;
         logic [3:0]  d;
         {wr, a, d} = VEC[v];
         access(wr, a, d, got, nrsp);
         check(m_row == a[19:10], "R2 row at row strobe", m_row, a[19:10]);
         check(m_col == a[9:0], "R2 column at column strobe", m_col, a[9:0]);
         check(m_rcd == E_RCD, "R3 row-to-column clocks", m_rcd, E_RCD);
         check(m_cas_len == E_CAS, "R3 column low clocks", m_cas_len, E_CAS);
         check(m_ras_len == E_RCD + E_CAS, "R3 row low clocks", m_ras_len, E_RCD + E_CAS);
         if (wr) begin
            check(!m_we_at_cas && !m_we_pre && m_oe_at_cas, "R5 early write strobes",
                  {m_we_pre, m_we_at_cas, m_oe_at_cas}, 1);
            check(m_dqoe && m_dq == d, "R5 write data driven", m_dq, d);
            check(nrsp == 0, "R9 no response for write", nrsp, 0);
         end else begin
            check(m_we_at_cas && !m_oe_at_cas, "R6 read strobes", {m_we_at_cas, m_oe_at_cas}, 2);
            check(got === d, "R6 read data", got, d);
            check(nrsp == 1, "R9 one response per read", nrsp, 1);
         end
      end

      check(rah_bad == 0, "R2 row held after row strobe", rah_bad, 0);
      check(m_min_hi >= E_RP, "R4 precharge clocks", m_min_hi, E_RP);
      check(m_min_per >= E_RC, "R4 cycle clocks", m_min_per, E_RC);
      check(rsp_long == 0, "R9 single-cycle pulse", rsp_long, 0);

      // R8 / R7: refresh and host read raised together
      @(negedge clk);
      falls0 = n_ras_falls;
      cbr0 = n_cbr;
      ref_req = 1'b1;
      req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h00401;
      #1;
      check(!req_ready, "R8 ready low with refresh pending", req_ready, 0);
      check(ref_ack, "R7 refresh ack when idle", ref_ack, 1);
      @(posedge clk);
      @(negedge clk);
      ref_req = 1'b0;
      check(!ref_ack, "R7 ack is one clock", ref_ack, 0);
      for (int i = 0; i < 50 && n_ras_falls == falls0; i++) @(negedge clk);
      check(m_cbr && n_cbr == cbr0 + 1, "R8 refresh served first", n_cbr - cbr0, 1);
      check(m_cas_lead == E_CSR, "R7 column before row clocks", m_cas_lead, E_CSR);
      for (int i = 0; i < 50 && !dram_ras_n; i++) @(negedge clk);
      @(negedge clk);
      check(m_ras_len == E_RREF, "R7 refresh row low clocks", m_ras_len, E_RREF);
      check(cbr_we_bad == 0, "R7 write enable high in refresh", cbr_we_bad, 0);
      got = 4'hx;
      for (int i = 0; i < 100 && !rsp_valid; i++) @(negedge clk);
      if (rsp_valid) got = rsp_rdata;
      req_valid = 1'b0;
      check(got === 4'h9, "R8 held read served after refresh", got, 9);
      for (int i = 0; i < 100 && !req_ready; i++) @(negedge clk);
      check(m_min_hi >= E_RP, "R4 precharge after refresh", m_min_hi, E_RP);

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule